// File: doc/BRIEF.md
# Byte-Memory Boot Loader

After reset this block copies the first stretch of program code from an external byte-wide memory into on-chip program memory. It reads the bytes one by one over a simple strobe/ready handshake. Every three bytes are packed into one 24-bit program word, and that word is written through an internal program-memory write port. While the copy runs, the processor core is kept in a wait state. Once the fixed first block of 32 words is in place, the core is released and told to start at program address 0. The code in that first block is then free to load the rest of the program by other means.

The mode inputs decide whether this boot path is used. They are sampled only while reset is asserted. When they select byte-memory boot, the loader's internal registers take fixed defaults during reset: transfer direction external-to-internal, 24-bit program word type, external byte address 0, internal word address 0, remaining-word count 32 and the core hold bit set. The sequence starts on the first cycle after reset is released. With any other mode value the block stays idle and the core is not held.

Top module: `byte_boot_loader`

## Requirements
- R1: When `boot_mode` is not 3'b001 while `rst` is high, the block stays idle after release: `bm_rd`, `pm_we`, `core_hold` and `boot_done` all stay 0.
- R2: While `rst` is high (sampled at the rising edge), `bm_rd`, `pm_we` and `boot_done` are 0, and `core_hold` equals 1 exactly when `boot_mode` is 3'b001.
- R3: A byte is accepted at a rising edge where `bm_rd` and `bm_ready` are both 1. `bm_addr` is 0 for the first read after reset, rises by one after every accepted byte, and holds steady while `bm_ready` is low.
- R4: Each program word is three consecutive accepted bytes: the first goes to `pm_wdata[23:16]`, the second to `[15:8]` and the third to `[7:0]`.
- R5: `pm_we` is high for exactly one cycle: the cycle after the edge that accepts the third byte of a word. Writes go to `pm_addr` 0, 1, 2 … in order, and there are exactly 32 of them.
- R6: Exactly 96 bytes are read. `bm_rd` stays high from release until the 96th byte is accepted, then stays low.
- R7: `core_hold` stays 1 from reset until the 32nd write. It goes to 0 on the edge that ends the cycle of the 32nd `pm_we`, and stays 0 until the next reset.
- R8: `boot_done` is a one-cycle pulse in the first cycle where `core_hold` is 0, and `core_pc` reads 0 in that cycle.
- R9: Changes on `boot_mode` after reset has been released have no effect on a running or idle sequence.
- R10: Asserting `rst` at any point, including partway through a load, restarts the sequence from byte address 0, word address 0 and a count of 32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| boot_mode | input | 3 | Configuration mode, sampled during reset; 3'b001 selects byte-memory boot |
| bm_addr | output | 14 | External byte-memory address |
| bm_rd | output | 1 | External byte read strobe |
| bm_data | input | 8 | Byte returned by external memory |
| bm_ready | input | 1 | External memory has the byte on `bm_data` |
| pm_we | output | 1 | Program-memory write enable |
| pm_addr | output | 14 | Program-memory word address |
| pm_wdata | output | 24 | Program-memory write data |
| core_hold | output | 1 | Keeps the core waiting while high |
| boot_done | output | 1 | One-cycle pulse when the core is released |
| core_pc | output | 14 | Start address handed to the core |

## Verification
The assertions assume that `bm_data` is valid whenever `bm_ready` is sampled high with `bm_rd`. They also assume that `rst` is the only way back to the start state, so that once `core_hold` has fallen it can only rise again through reset. The bench drives `bm_data` combinationally from a byte model indexed by `bm_addr`. It changes `bm_ready` and the mode and reset inputs only between clock edges. Ready patterns run from always-ready to long random stalls.

// File: rtl/boot_ldr_pkg.sv
package boot_ldr_pkg;

    localparam int BYTE_W    = 8;
    localparam int PM_WORD_W = 24;

    typedef enum logic {
        DIR_EXT_TO_INT = 1'b0,
        DIR_INT_TO_EXT = 1'b1
    } xfer_dir_e;

    typedef enum logic [1:0] {
        WT_PM24   = 2'd0,
        WT_DM16   = 2'd1,
        WT_DM8_HI = 2'd2,
        WT_DM8_LO = 2'd3
    } word_type_e;

    typedef struct packed {
        xfer_dir_e  dir;
        word_type_e wtype;
    } xfer_cfg_t;

    // Defaults applied while reset is held
    localparam xfer_cfg_t BOOT_CFG = '{dir: DIR_EXT_TO_INT, wtype: WT_PM24};

    function automatic int bytes_per_word(word_type_e t);
        case (t)
            WT_PM24: return 3;
            WT_DM16: return 2;
            default: return 1;
        endcase
    endfunction

endpackage

// File: rtl/boot_byte_fetch.sv
module boot_byte_fetch
    import boot_ldr_pkg::*;
#(
    parameter int EXT_AW      = 14,
    parameter int TOTAL_BYTES = 96
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fetch_en,
    input  logic              mem_ready,
    output logic              mem_rd,
    output logic [EXT_AW-1:0] mem_addr,
    output logic              byte_take
);
    localparam int BUD_W = $clog2(TOTAL_BYTES + 1);

    logic [EXT_AW-1:0] addr_q;
    logic [BUD_W-1:0]  budget_q;

    assign mem_rd    = fetch_en && (budget_q != '0);
    assign byte_take = mem_rd && mem_ready;
    assign mem_addr  = addr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q   <= '0;
            budget_q <= BUD_W'(TOTAL_BYTES);
        end else if (byte_take) begin
            addr_q   <= addr_q + 1'b1;
            budget_q <= budget_q - 1'b1;
        end
    end

endmodule

// File: rtl/boot_word_pack.sv
module boot_word_pack
    import boot_ldr_pkg::*;
#(
    parameter int NBYTES = 3
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     byte_vld,
    input  logic [BYTE_W-1:0]        byte_in,
    output logic                     word_vld,
    output logic [NBYTES*BYTE_W-1:0] word_data
);
    localparam int WORD_W = NBYTES * BYTE_W;

    generate
        if (NBYTES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) begin
                    word_vld  <= 1'b0;
                    word_data <= '0;
                end else begin
                    word_vld <= byte_vld;
                    if (byte_vld) word_data <= byte_in;
                end
            end
        end else begin : g_multi
            localparam int ACC_W  = (NBYTES - 1) * BYTE_W;
            localparam int LANE_W = $clog2(NBYTES);

            logic [ACC_W-1:0]  acc_q;
            logic [LANE_W-1:0] lane_q;

            always_ff @(posedge clk) begin
                if (rst) begin
                    acc_q     <= '0;
                    lane_q    <= '0;
                    word_vld  <= 1'b0;
                    word_data <= '0;
                end else begin
                    word_vld <= 1'b0;
                    if (byte_vld) begin
                        if (lane_q == LANE_W'(NBYTES - 1)) begin
                            // earliest byte ends up in the top lane
                            word_data <= WORD_W'({acc_q, byte_in});
                            word_vld  <= 1'b1;
                            lane_q    <= '0;
                        end else begin
                            acc_q  <= (acc_q << BYTE_W) | ACC_W'(byte_in);
                            lane_q <= lane_q + 1'b1;
                        end
                    end
                end
            end
        end
    endgenerate

endmodule

// File: rtl/boot_seq_ctrl.sv
module boot_seq_ctrl
    import boot_ldr_pkg::*;
#(
    parameter int                PM_AW      = 14,
    parameter int                BOOT_WORDS = 32,
    parameter int                MODE_W     = 3,
    parameter logic [MODE_W-1:0] BOOT_MODE  = 3'b001
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [MODE_W-1:0] mode_in,
    input  logic              word_vld,
    output logic              hold,
    output logic              done,
    output logic              wr_en,
    output logic [PM_AW-1:0]  wr_addr
);
    localparam int CNT_W = $clog2(BOOT_WORDS + 1);

    logic [CNT_W-1:0] count_q;
    logic [PM_AW-1:0] addr_q;
    logic             hold_q;
    logic             done_q;

    assign wr_en   = word_vld && hold_q;
    assign wr_addr = addr_q;
    assign hold    = hold_q;
    assign done    = done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q  <= (mode_in == BOOT_MODE);
            count_q <= CNT_W'(BOOT_WORDS);
            addr_q  <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (wr_en) begin
                addr_q  <= addr_q + 1'b1;
                count_q <= count_q - 1'b1;
                if (count_q == CNT_W'(1)) begin
                    hold_q <= 1'b0;
                    done_q <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/byte_boot_loader.sv
module byte_boot_loader
    import boot_ldr_pkg::*;
#(
    parameter int                EXT_AW     = 14,
    parameter int                PM_AW      = 14,
    parameter int                BOOT_WORDS = 32,
    parameter int                MODE_W     = 3,
    parameter logic [MODE_W-1:0] BOOT_MODE  = 3'b001
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [MODE_W-1:0]    boot_mode,
    output logic [EXT_AW-1:0]    bm_addr,
    output logic                 bm_rd,
    input  logic [BYTE_W-1:0]    bm_data,
    input  logic                 bm_ready,
    output logic                 pm_we,
    output logic [PM_AW-1:0]     pm_addr,
    output logic [PM_WORD_W-1:0] pm_wdata,
    output logic                 core_hold,
    output logic                 boot_done,
    output logic [PM_AW-1:0]     core_pc
);
    localparam int NBYTES      = bytes_per_word(BOOT_CFG.wtype);
    localparam int TOTAL_BYTES = BOOT_WORDS * NBYTES;

    logic                     hold_w;
    logic                     byte_take;
    logic                     word_vld;
    logic [NBYTES*BYTE_W-1:0] word_data;

    boot_byte_fetch #(
        .EXT_AW      (EXT_AW),
        .TOTAL_BYTES (TOTAL_BYTES)
    ) u_fetch (
        .clk       (clk),
        .rst       (rst),
        .fetch_en  (hold_w && !rst),
        .mem_ready (bm_ready),
        .mem_rd    (bm_rd),
        .mem_addr  (bm_addr),
        .byte_take (byte_take)
    );

    boot_word_pack #(
        .NBYTES (NBYTES)
    ) u_pack (
        .clk       (clk),
        .rst       (rst),
        .byte_vld  (byte_take),
        .byte_in   (bm_data),
        .word_vld  (word_vld),
        .word_data (word_data)
    );

    boot_seq_ctrl #(
        .PM_AW      (PM_AW),
        .BOOT_WORDS (BOOT_WORDS),
        .MODE_W     (MODE_W),
        .BOOT_MODE  (BOOT_MODE)
    ) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .mode_in  (boot_mode),
        .word_vld (word_vld),
        .hold     (hold_w),
        .done     (boot_done),
        .wr_en    (pm_we),
        .wr_addr  (pm_addr)
    );

    assign pm_wdata  = PM_WORD_W'(word_data);
    assign core_hold = hold_w;
    assign core_pc   = '0;

endmodule

// File: rtl/byte_boot_loader_chk.sv
module byte_boot_loader_chk #(
    parameter int EXT_AW = 14,
    parameter int PM_AW  = 14
) (
    input logic              clk,
    input logic              rst,
    input logic [EXT_AW-1:0] bm_addr,
    input logic              bm_rd,
    input logic              bm_ready,
    input logic              pm_we,
    input logic [PM_AW-1:0]  pm_addr,
    input logic              core_hold,
    input logic              boot_done
);
    AST_ADDR_WAIT: assert property (@(posedge clk) disable iff (rst)
        (bm_rd && !bm_ready) |=> $stable(bm_addr)); // R3
    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
        (bm_rd && bm_ready) |=> (bm_addr == $past(bm_addr) + 1'b1)); // R3
    AST_PM_STEP: assert property (@(posedge clk) disable iff (rst)
        pm_we |=> (pm_addr == $past(pm_addr) + 1'b1)); // R5
    AST_RD_IN_HOLD: assert property (@(posedge clk) disable iff (rst)
        bm_rd |-> core_hold); // R6
    AST_WE_IN_HOLD: assert property (@(posedge clk) disable iff (rst)
        pm_we |-> core_hold); // R7
    AST_HOLD_NO_RISE: assert property (@(posedge clk) disable iff (rst)
        !core_hold |=> !core_hold); // R7
    AST_DONE_AFTER_WE: assert property (@(posedge clk) disable iff (rst)
        boot_done |-> ($past(pm_we) && !core_hold)); // R8
    AST_DONE_ONE: assert property (@(posedge clk) disable iff (rst)
        boot_done |=> !boot_done); // R8
endmodule

bind byte_boot_loader byte_boot_loader_chk #(
    .EXT_AW (EXT_AW),
    .PM_AW  (PM_AW)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bm_addr   (bm_addr),
    .bm_rd     (bm_rd),
    .bm_ready  (bm_ready),
    .pm_we     (pm_we),
    .pm_addr   (pm_addr),
    .core_hold (core_hold),
    .boot_done (boot_done)
);

// File: tb/byte_boot_loader_test.sv
`timescale 1ns/1ps
module byte_boot_loader_test;
    localparam int         EXT_AW = 14;
    localparam int         PM_AW  = 14;
    localparam int         WORDS  = 32;
    localparam int         TOTAL  = 96;
    localparam logic [2:0] MODE_BOOT = 3'b001;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [2:0]        boot_mode = MODE_BOOT;
    logic [EXT_AW-1:0] bm_addr;
    logic              bm_rd;
    logic [7:0]        bm_data;
    logic              bm_ready = 1'b0;
    logic              pm_we;
    logic [PM_AW-1:0]  pm_addr;
    logic [23:0]       pm_wdata;
    logic              core_hold;
    logic              boot_done;
    logic [PM_AW-1:0]  core_pc;

    always #2.5 clk = ~clk;

    int       checks = 0;
    int       fails = 0;
    logic [7:0] salt = 8'h00;
    int       ready_mode = 0;
    bit       exp_boot = 1'b1;
    bit       mon_on = 1'b0;
    int       acc_cnt = 0;
    int       wr_cnt = 0;
    bit       pend_word = 1'b0;
    bit       done_due = 1'b0;
    bit       finished = 1'b0;

    function automatic logic [7:0] rom_byte(int a, logic [7:0] s);
        return 8'(a * 29) ^ 8'(a >> 3) ^ s;
    endfunction

    function automatic logic [23:0] exp_word(int i, logic [7:0] s);
        return {rom_byte(3*i, s), rom_byte(3*i + 1, s), rom_byte(3*i + 2, s)};
    endfunction

    assign bm_data = rom_byte(int'(bm_addr), salt);

    byte_boot_loader uut (
        .clk       (clk),
        .rst       (rst),
        .boot_mode (boot_mode),
        .bm_addr   (bm_addr),
        .bm_rd     (bm_rd),
        .bm_data   (bm_data),
        .bm_ready  (bm_ready),
        .pm_we     (pm_we),
        .pm_addr   (pm_addr),
        .pm_wdata  (pm_wdata),
        .core_hold (core_hold),
        .boot_done (boot_done),
        .core_pc   (core_pc)
    );

    task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h t=%0t", req, what, act, exp, $time);
        end
    endtask

    function automatic logic pick_ready(int m);
        case (m)
            0:       return 1'b1;
            1:       return 1'($urandom_range(0, 1));
            default: return ($urandom_range(0, 4) == 0);
        endcase
    endfunction

    // cycle monitor: checks outputs and drives bm_ready between edges
    initial begin
        forever begin
            @(negedge clk);
            if (rst || !mon_on) begin
                bm_ready  = 1'b0;
                pend_word = 1'b0;
            end else if (!exp_boot) begin
                check(!bm_rd && !pm_we && !core_hold && !boot_done, "R1", "idle outputs",
                      {28'd0, bm_rd, pm_we, core_hold, boot_done}, 32'd0);
                bm_ready = 1'($urandom_range(0, 1));
            end else begin
                if (bm_rd)
                    check(bm_addr == EXT_AW'(acc_cnt) && acc_cnt < TOTAL, "R3", "bm_addr",
                          32'(bm_addr), 32'(acc_cnt));
                else if (!finished && !done_due && acc_cnt < TOTAL)
                    check(1'b0, "R6", "bm_rd low before 96 bytes", 32'd0, 32'd1);
                check(boot_done == done_due, "R8", "boot_done", 32'(boot_done), 32'(done_due));
                check(core_hold == !(done_due || finished), "R7", "core_hold",
                      32'(core_hold), 32'(!(done_due || finished)));
                if (done_due) check(core_pc == '0, "R8", "core_pc", 32'(core_pc), 32'd0);
                finished = finished || done_due;
                done_due = 1'b0;
                check(pm_we == pend_word, "R5", "pm_we timing", 32'(pm_we), 32'(pend_word));
                if (pm_we) begin
                    check(pm_addr == PM_AW'(wr_cnt), "R5", "pm_addr", 32'(pm_addr), 32'(wr_cnt));
                    check(pm_wdata == exp_word(wr_cnt, salt), "R4", "pm_wdata",
                          32'(pm_wdata), 32'(exp_word(wr_cnt, salt)));
                    wr_cnt++;
                    if (wr_cnt == WORDS) done_due = 1'b1;
                end
                bm_ready  = pick_ready(ready_mode);
                pend_word = 1'b0;
                if (bm_rd && bm_ready) begin
                    acc_cnt++;
                    if (acc_cnt % 3 == 0) pend_word = 1'b1;
                end
            end
        end
    end

    // stop_at < 0: run to the end; otherwise abandon once that many words are written
    task automatic run_boot(logic [2:0] mval, int rmode, logic [7:0] s, bit flip_mode, int stop_at);
        @(posedge clk); #1;
        rst = 1'b1; boot_mode = mval; salt = s; ready_mode = rmode;
        exp_boot = (mval == MODE_BOOT); mon_on = 1'b1;
        acc_cnt = 0; wr_cnt = 0; done_due = 1'b0; finished = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        check(!bm_rd && !pm_we && !boot_done, "R2", "strobes in reset",
              {29'd0, bm_rd, pm_we, boot_done}, 32'd0);
        check(core_hold == exp_boot, "R2", "core_hold in reset", 32'(core_hold), 32'(exp_boot));
        rst = 1'b0;
        #0.5;
        if (exp_boot)
            check(bm_rd && bm_addr == '0 && pm_addr == '0, "R10", "start state after release",
                  {bm_rd, 3'd0, 14'(bm_addr), 14'(pm_addr)}, 32'h8000_0000);
        begin
            int cyc;
            for (cyc = 0; cyc < 4000; cyc++) begin
                @(posedge clk); #1;
                if (flip_mode && cyc == 15) boot_mode = exp_boot ? 3'b110 : MODE_BOOT; // R9
                if (stop_at >= 0 && wr_cnt >= stop_at) break;
                if (exp_boot && finished) break;
                if (!exp_boot && cyc >= 300) break;
            end
            if (stop_at < 0) begin
                repeat (20) @(posedge clk);
                #1;
                if (exp_boot) begin
                    check(finished, "R7", "core released", 32'(finished), 32'd1);
                    check(acc_cnt == TOTAL, "R6", "bytes read", 32'(acc_cnt), 32'(TOTAL));
                    check(wr_cnt == WORDS, "R5", "words written", 32'(wr_cnt), 32'(WORDS));
                    if (flip_mode) check(finished && wr_cnt == WORDS, "R9", "mode flip ignored",
                                         32'(wr_cnt), 32'(WORDS));
                end else begin
                    check(acc_cnt == 0 && wr_cnt == 0, "R1", "no traffic", 32'(acc_cnt + wr_cnt), 32'd0);
                    if (flip_mode) check(!core_hold && !bm_rd, "R9", "late mode select ignored",
                                         {30'd0, core_hold, bm_rd}, 32'd0);
                end
            end
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        run_boot(MODE_BOOT, 0, 8'h00, 1'b0, -1);   // back-to-back bytes
        run_boot(MODE_BOOT, 1, 8'h5a, 1'b0, -1);   // random ready
        run_boot(MODE_BOOT, 2, 8'hc3, 1'b0, -1);   // long stalls
        run_boot(3'b000,    1, 8'h11, 1'b0, -1);   // other mode: idle
        run_boot(3'b101,    1, 8'h22, 1'b1, -1);   // boot value applied after release
        run_boot(MODE_BOOT, 1, 8'h3c, 1'b1, -1);   // mode flipped mid-load
        run_boot(MODE_BOOT, 1, 8'h77, 1'b0, 10);   // abandoned partway by reset
        run_boot(MODE_BOOT, 2, 8'h99, 1'b0, -1);   // R10 full restart afterwards
        run_boot(MODE_BOOT, 0, 8'hff, 1'b0, 31);   // reset one word before the end
        run_boot(MODE_BOOT, 0, 8'h01, 1'b0, -1);
        mon_on = 1'b0;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule